// File: doc/BRIEF.md
# 32-Line GPIO Port with Set/Clear Output Control

This block is a general-purpose I/O port for up to 32 lines behind a single-cycle register bus. The output latch cannot be written directly. Software raises lines by writing ones to a set register and lowers them by writing ones to a clear register. Bits written as zero leave their lines alone. A test port can apply a set mask and a clear mask in the same cycle. When both masks name the same bit, the clear wins.

Readback comes in two forms. The output status register returns the value the port is commanding. The pin status register returns the level actually present on each pad, whatever the line's direction or driver mode. Pad levels pass through a two-stage synchroniser. That synchroniser only advances while the port clock enable is high, so the pin status keeps the last sampled levels while the enable is low.

Each line has an output-enable bit and an open-drain bit. In open-drain mode a line can read low while its commanded value is 1. The pads are modelled as a drive-value vector, a drive-enable vector and a pad-input vector.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output latch, direction register, open-drain register, pin synchroniser and read data are all zero, and every pad drive enable is low.
- R2: A bus write to address 0x0 (set) sets every output latch bit whose written bit is 1.
- R3: A bus write to address 0x1 (clear) clears every output latch bit whose written bit is 1.
- R4: Output latch bits written as 0 through the set or clear path, or not written at all, keep their value.
- R5: When the same bit appears in both the set and the clear mask in one cycle, that bit ends up 0. The masks can come from the test port, which has a strobe and two masks, or from the test port combined with a bus write.
- R6: Bus read data is registered. It returns, one cycle later, the register selected by the address presented in the current cycle. Address 0x2 returns the output latch.
- R7: Address 0x3 returns the pad-input levels through two synchroniser stages. A pad change that occurs before clock edge k is visible on bus read data after edge k+2, and not after edge k+1.
- R8: While the clock enable is 0, the pin status stays frozen at the levels sampled before it went low. Bus writes and the output latch keep working during this time.
- R9: Address 0x4 is the read/write direction register and address 0x5 is the read/write open-drain register. Reads of 0x0, 0x1 and any unmapped address return 0.
- R10: In push-pull mode (open-drain bit 0), a pad's drive enable equals its direction bit and its drive value equals its output latch bit.
- R11: In open-drain mode (open-drain bit 1), a pad's drive value is 0 and its drive is enabled only when the direction bit is 1 and the output latch bit is 0. As a result, the pin status can read 0 while the output latch reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Port clock enable for the pin synchroniser |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tp_wr | input | 1 | Test-port dual-write strobe |
| tp_set | input | 32 | Test-port set mask |
| tp_clr | input | 32 | Test-port clear mask |
| pad_in | input | 32 | Level present on each pad |
| pad_do | output | 32 | Pad drive value |
| pad_oe | output | 32 | Pad drive enable |

## Verification
The bench builds the port with its default of 32 lines and two synchroniser stages. With 32 lines, full-width random masks reach the top and bottom bits in every set, clear and dual-write step. With two stages, the exact edge at which a pad change reaches the read data can be pinned down directly. A bench model of the pads resolves driven lines against an external level. This lets the bench observe open-drain lines reading low while their latch bit is 1, and observe the pin status holding while the clock enable is low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_SET = 4'h0,
        A_CLR = 4'h1,
        A_OUT = 4'h2,
        A_PIN = 4'h3,
        A_DIR = 4'h4,
        A_ODM = 4'h5
    } reg_addr_e;
endpackage

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic              tp_wr,
    input  logic [N-1:0]      tp_set,
    input  logic [N-1:0]      tp_clr,
    output logic [N-1:0]      out_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      od_q
);
    logic [N-1:0] set_w, clr_w;

    always_comb begin
        set_w = tp_wr ? tp_set : '0;
        clr_w = tp_wr ? tp_clr : '0;
        if (bus_wr && bus_addr == A_SET) set_w = set_w | bus_wdata;
        if (bus_wr && bus_addr == A_CLR) clr_w = clr_w | bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            od_q  <= '0;
        end else begin
            out_q <= (out_q | set_w) & ~clr_w;
            if (bus_wr && bus_addr == A_DIR) dir_q <= bus_wdata;
            if (bus_wr && bus_addr == A_ODM) od_q  <= bus_wdata;
        end
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_w & ~clr_w) != '0) |=> ((out_q & $past(set_w & ~clr_w)) == $past(set_w & ~clr_w)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w != '0) |=> ((out_q & $past(clr_w)) == '0));

    // R4
    untouched_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(set_w | clr_w)) == '0));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] pin_q
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg[0] <= '0;
        else if (clk_en) stg[0] <= pad_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[k] <= '0;
            else if (clk_en) stg[k] <= stg[k-1];
        end
    end

    assign pin_q = stg[STAGES-1];

    // R8
    pin_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(pin_q));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int N = 32
) (
    input  logic [N-1:0] out_q,
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] od_q,
    output logic [N-1:0] pad_do,
    output logic [N-1:0] pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_comb begin
            if (od_q[i]) begin
                pad_do[i] = 1'b0;
                pad_oe[i] = dir_q[i] & ~out_q[i];
            end else begin
                pad_do[i] = out_q[i];
                pad_oe[i] = dir_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic              tp_wr,
    input  logic [N-1:0]      tp_set,
    input  logic [N-1:0]      tp_clr,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_do,
    output logic [N-1:0]      pad_oe
);
    logic [N-1:0] out_q, dir_q, od_q, pin_q, rd_mux;

    gpio_out_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tp_wr(tp_wr), .tp_set(tp_set), .tp_clr(tp_clr),
        .out_q(out_q), .dir_q(dir_q), .od_q(od_q)
    );

    gpio_in_sync #(.N(N), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pad_in(pad_in), .pin_q(pin_q)
    );

    gpio_pad_ctrl #(.N(N)) u_pad (
        .out_q(out_q), .dir_q(dir_q), .od_q(od_q), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    always_comb begin
        case (bus_addr)
            A_OUT:   rd_mux = out_q;
            A_PIN:   rd_mux = pin_q;
            A_DIR:   rd_mux = dir_q;
            A_ODM:   rd_mux = od_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_mux;
    end

    // R6
    read_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_OUT) |=> (bus_rdata == $past(out_q)));

    // R11
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_do & od_q) == '0));

    // R10
    pp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~od_q) == (dir_q & ~od_q)));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b1;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         tp_wr = 1'b0;
    logic [N-1:0] tp_set = '0, tp_clr = '0;
    logic [N-1:0] pad_in, pad_do, pad_oe;
    logic [N-1:0] ext = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // pad model: driven lines take the drive value, others the external level
    assign pad_in = (pad_oe & pad_do) | (~pad_oe & ext);

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tp_wr(tp_wr), .tp_set(tp_set), .tp_clr(tp_clr),
        .pad_in(pad_in), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [N-1:0] v);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    function automatic logic [N-1:0] f_next(logic [N-1:0] cur, logic [N-1:0] s, logic [N-1:0] c);
        return (cur | s) & ~c;
    endfunction

    function automatic logic [N-1:0] f_oe(logic [N-1:0] o, logic [N-1:0] d, logic [N-1:0] m);
        return (d & ~m) | (d & m & ~o);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] v, model, dir_m, od_m, m1, m2, old_pin;
        void'($urandom(32'h1234_5eed));
        model = '0; dir_m = '0; od_m = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 rdata", bus_rdata, '0);
        rst_n = 1'b1;
        bus_read(4'h2, v); check("R1 out", v, '0);
        bus_read(4'h4, v); check("R1 dir", v, '0);
        bus_read(4'h3, v); check("R1 pin", v, '0);

        // R2 / R3 / R4 directed
        bus_write(4'h0, 32'h8000_0001); model = 32'h8000_0001;
        bus_read(4'h2, v); check("R2 set edges", v, model);
        bus_write(4'h0, 32'h0000_0000);
        bus_read(4'h2, v); check("R4 zero set", v, model);
        bus_write(4'h1, 32'h0000_0001); model = 32'h8000_0000;
        bus_read(4'h2, v); check("R3 clear", v, model);
        bus_write(4'h1, 32'h0000_0000);
        bus_read(4'h2, v); check("R4 zero clear", v, model);

        // R5 dual write, clear wins
        @(negedge clk);
        tp_wr = 1'b1; tp_set = 32'h00FF_00FF; tp_clr = 32'h0F0F_0F0F;
        @(negedge clk);
        tp_wr = 1'b0; model = f_next(model, 32'h00FF_00FF, 32'h0F0F_0F0F);
        bus_read(4'h2, v); check("R5 tp overlap", v, model);
        // R5 bus set with tp clear same bit
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0000_0F00;
        tp_wr = 1'b1; tp_set = '0; tp_clr = 32'h0000_0100;
        @(negedge clk);
        bus_wr = 1'b0; tp_wr = 1'b0; tp_clr = '0;
        model = f_next(model, 32'h0000_0F00, 32'h0000_0100);
        bus_read(4'h2, v); check("R5 bus set vs tp clr", v, model);

        // R9 register map
        bus_write(4'h4, 32'hA5A5_0000); dir_m = 32'hA5A5_0000;
        bus_write(4'h5, 32'h0000_5A5A); od_m = 32'h0000_5A5A;
        bus_read(4'h4, v); check("R9 dir rw", v, dir_m);
        bus_read(4'h5, v); check("R9 od rw", v, od_m);
        bus_read(4'h0, v); check("R9 set reads 0", v, '0);
        bus_read(4'h1, v); check("R9 clr reads 0", v, '0);
        bus_read(4'hE, v); check("R9 unmapped", v, '0);

        // Random mix, R2 R3 R4 R5 R6 R10 R11
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom % 5;
            m1 = $urandom; m2 = $urandom;
            case (op)
                0: begin bus_write(4'h0, m1); model = f_next(model, m1, '0); end
                1: begin bus_write(4'h1, m1); model = f_next(model, '0, m1); end
                2: begin
                    @(negedge clk);
                    tp_wr = 1'b1; tp_set = m1; tp_clr = m2;
                    @(negedge clk);
                    tp_wr = 1'b0; model = f_next(model, m1, m2);
                end
                3: begin bus_write(4'h4, m1); dir_m = m1; end
                default: begin bus_write(4'h5, m1); od_m = m1; end
            endcase
            bus_read(4'h2, v); check("R6 out readback (R2 R3 R4 R5)", v, model);
            check("R10 R11 pad_oe", pad_oe, f_oe(model, dir_m, od_m));
            check("R10 R11 pad_do", pad_do, model & ~od_m);
        end

        // R7 latency: all inputs, external drive
        bus_write(4'h4, '0); dir_m = '0;
        ext = 32'h1111_2222;
        repeat (4) @(negedge clk);
        bus_addr = 4'h3;
        @(negedge clk);
        old_pin = ext;
        ext = 32'hCAFE_F00D;
        @(negedge clk); @(negedge clk);
        check("R7 not yet after k+1", bus_rdata, old_pin);
        @(negedge clk);
        check("R7 visible after k+2", bus_rdata, 32'hCAFE_F00D);

        // R8 freeze
        @(negedge clk);
        clk_en = 1'b0; ext = 32'h0BAD_BEEF;
        repeat (6) @(negedge clk);
        bus_read(4'h3, v); check("R8 pin frozen", v, 32'hCAFE_F00D);
        bus_write(4'h0, 32'h0000_0010); model = f_next(model, 32'h0000_0010, '0);
        bus_read(4'h2, v); check("R8 out live while gated", v, model);
        @(negedge clk); clk_en = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(4'h3, v); check("R8 pin resumes", v, 32'h0BAD_BEEF);

        // R10 push-pull drives pad, pin follows latch
        bus_write(4'h5, '0); od_m = '0;
        bus_write(4'h4, '1); dir_m = '1;
        ext = '0;
        repeat (4) @(negedge clk);
        bus_read(4'h3, v); check("R10 pin follows latch", v, model);

        // R11 open-drain: latch 1 with external low reads 0
        bus_write(4'h0, '1); model = '1;
        bus_write(4'h5, '1); od_m = '1;
        ext = 32'h0000_FFFF;
        repeat (4) @(negedge clk);
        bus_read(4'h2, v); check("R11 latch high", v, '1);
        bus_read(4'h3, v); check("R11 pin low upper", v, 32'h0000_FFFF);
        check("R11 released", pad_oe, '0);
        bus_write(4'h1, 32'h0000_00FF); model = 32'hFFFF_FF00;
        repeat (4) @(negedge clk);
        check("R11 drives low", pad_oe, 32'h0000_00FF);
        bus_read(4'h3, v); check("R11 pin pulled low", v, 32'h0000_FF00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule